// File: doc/BRIEF.md
# Multi-Lane Link Synchronization Controller

This block sits above the per-lane code-group-sync machines of a multi-lane serial receiver. Every lane reports its current phase (INIT, CHECK or DATA), and the controller decides when the link as a whole may be treated as synchronized. It does not trust the first cycle in which all lanes reach DATA. Instead, it runs a deglitch window that needs an unbroken stretch of all-DATA cycles. Any dropout during that window sends it back to waiting, and the window starts again from the beginning.

The controller also keeps a saturating error counter fed by per-lane error strobes. This count is wiped at the moment the link becomes synchronized, so errors picked up during bring-up do not stay in it. After that point, errors keep accumulating until the link is disabled. Frame-alignment error strobes are passed on per lane only while that lane is in DATA. All event generation is held in reset whenever the link is not enabled.

Top module: `link_sync_ctrl`

## Requirements
- R1: After reset, `link_state` is 0 (encoding: 0 idle, 1 waiting for lanes, 2 deglitch, 3 synchronized), `link_synced` is 0, `err_count` is 0 and `frame_err_evt` is 0. With `link_en` high, the idle state moves to waiting on the next clock.
- R2: Lane i reports its phase on `lane_phase[2i+1:2i]`: 0 = INIT, 1 = CHECK, 2 = DATA, and 3 counts as not DATA. `link_synced` rises after 256 consecutive sampled clocks in which every lane is in DATA, and not after 255. The count begins with the first such clock seen while waiting.
- R3: If any lane is not in DATA during the deglitch window, the controller goes back to waiting on the next clock. The 256-clock run then restarts from zero.
- R4: On the clock that enters the synchronized state, `err_count` becomes 0. Any errors strobed in that same clock are discarded.
- R5: Once synchronized, the link stays synchronized while `link_en` is high, whatever the lane phases do. Errors strobed after that point keep adding to `err_count`.
- R6: `frame_err_evt[i]` is a registered copy of `lane_frame_err[i]`, one clock later. It is forced to 0 whenever lane i was not in DATA or `link_en` was low in the sampled clock.
- R7: While `link_en` is low, on the next clock the state is idle, `link_synced` is 0, `err_count` is 0 and `frame_err_evt` is 0. Error strobes have no effect while it stays low.
- R8: `err_count` saturates at its all-ones value instead of wrapping.
- R9: In each enabled clock that is not a synchronized-entry clock, `err_count` grows by the number of set bits of `lane_err`, one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Link enable; low holds the controller and events in reset |
| lane_phase | input | 2*NUM_LANES | Per-lane sync phase, 2 bits per lane |
| lane_err | input | NUM_LANES | Per-lane error strobes feeding the counter |
| lane_frame_err | input | NUM_LANES | Per-lane frame-alignment error strobes |
| link_state | output | 2 | Current controller state |
| link_synced | output | 1 | High in the synchronized state |
| err_count | output | ERR_W | Saturating accumulated error count |
| frame_err_evt | output | NUM_LANES | Gated, registered frame-alignment events |

## Verification
Every output is registered, so each result is due exactly one clock after the inputs that cause it. The one exception is `link_synced`, which is due after the 256th consecutive all-DATA clock, counted from the first one sampled in the waiting state. The bench changes its inputs on the falling edge and samples outputs on the next falling edge. In this way each check lands one rising edge after its stimulus. For the deglitch it counts rising edges explicitly and checks at 255 and at 256. The saturation value and the clear-on-entry are checked on the two sides of that same final edge.

// File: rtl/lsc_pkg.sv
// Shared types for the link synchronization controller.
// Assumes two-bit lane phase codes and two-bit controller state codes.
package lsc_pkg;

    typedef enum logic [1:0] {
        PH_INIT  = 2'd0,
        PH_CHECK = 2'd1,
        PH_DATA  = 2'd2
    } lane_phase_e;

    typedef enum logic [1:0] {
        LS_IDLE     = 2'd0,
        LS_WAIT     = 2'd1,
        LS_DEGLITCH = 2'd2,
        LS_SYNC     = 2'd3
    } link_state_e;

endpackage

// File: rtl/lsc_lane_gate.sv
// Per-lane phase decode and frame-alignment event gating.
// Flags each lane that is in DATA (combinational) and registers its
// frame-alignment strobe only when the lane is in DATA and the link is enabled.
// Assumes lane_phase packs lane i at bits [2i+1:2i].
module lsc_lane_gate
    import lsc_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   link_en,
    input  logic [2*NUM_LANES-1:0] lane_phase,
    input  logic [NUM_LANES-1:0]   lane_frame_err,
    output logic [NUM_LANES-1:0]   lane_in_data,
    output logic [NUM_LANES-1:0]   frame_err_evt
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Decode whether this lane currently reports DATA.
        always_comb begin
            lane_in_data[g] = (lane_phase[2*g +: 2] == PH_DATA);
        end

        // Register the frame error only for an enabled lane in DATA.
        always_ff @(posedge clk) begin
            if (!rst_n || !link_en) begin
                frame_err_evt[g] <= 1'b0;
            end else begin
                frame_err_evt[g] <= lane_frame_err[g] & lane_in_data[g];
            end
        end

        AST_FRAME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            frame_err_evt[g] |-> ($past(lane_phase[2*g +: 2]) == PH_DATA) && $past(link_en)) // R6
            else $error("frame event from lane outside DATA");
    end

endmodule

// File: rtl/lsc_link_fsm.sv
// Link state machine with deglitch window.
// Moves idle -> waiting -> deglitch -> synchronized. The deglitch needs
// DEGLITCH_CYCLES consecutive all-DATA clocks, including the first one seen
// while waiting. Any dropout returns to waiting. Disable returns to idle.
module lsc_link_fsm
    import lsc_pkg::*;
#(
    parameter int DEGLITCH_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_en,
    input  logic       all_data,
    output logic [1:0] state,
    output logic       enter_sync
);

    localparam int CNT_W = $clog2(DEGLITCH_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEGLITCH_CYCLES - 1);

    link_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and deglitch counter logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!link_en) begin
            state_d = LS_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                LS_IDLE: begin
                    state_d = LS_WAIT;
                    cnt_d   = '0;
                end
                LS_WAIT: begin
                    if (all_data) begin
                        state_d = LS_DEGLITCH;
                        cnt_d   = CNT_W'(1);
                    end
                end
                LS_DEGLITCH: begin
                    if (!all_data) begin
                        state_d = LS_WAIT;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_d = LS_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                LS_SYNC: begin
                    state_d = LS_SYNC;
                end
                default: state_d = LS_IDLE;
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Flag the clock that enters the synchronized state.
    always_comb begin
        enter_sync = (state_q == LS_DEGLITCH) && (state_d == LS_SYNC);
    end

    assign state = state_q;

    AST_SYNC_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SYNC && $past(state_q) != LS_SYNC) |-> $past(all_data) && $past(state_q) == LS_DEGLITCH) // R2
        else $error("synchronized entered without all lanes in DATA");

    AST_DROPOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_DEGLITCH && !all_data && link_en) |=> (state_q == LS_WAIT)) // R3
        else $error("dropout did not restart deglitch");

    AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SYNC && link_en) |=> (state_q == LS_SYNC)) // R5
        else $error("synchronized state lost while enabled");

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (state_q == LS_IDLE)) // R7
        else $error("disable did not return to idle");

endmodule

// File: rtl/lsc_err_counter.sv
// Saturating error accumulator.
// Adds the number of set lane error strobes each clock. Clears on entry to
// the synchronized state and while the link is disabled.
module lsc_err_counter #(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 link_en,
    input  logic                 clear,
    input  logic [NUM_LANES-1:0] lane_err,
    output logic [ERR_W-1:0]     count
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic [ERR_W:0] inc;
    logic [ERR_W:0] sum;

    // Population count of this clock's error strobes.
    always_comb begin
        inc = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            inc = inc + (ERR_W+1)'(lane_err[i]);
        end
        sum = {1'b0, count} + inc;
    end

    // Accumulate with saturation; clear on reset, disable or sync entry.
    always_ff @(posedge clk) begin
        if (!rst_n || !link_en || clear) begin
            count <= '0;
        end else if (sum > {1'b0, CNT_MAX}) begin
            count <= CNT_MAX;
        end else begin
            count <= sum[ERR_W-1:0];
        end
    end

    AST_CLEAR_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)) // R4
        else $error("count not cleared on sync entry");

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX && link_en && !clear) |=> (count == CNT_MAX)) // R8
        else $error("count wrapped past maximum");

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (count == '0)) // R7
        else $error("count moved while disabled");

endmodule

// File: rtl/link_sync_ctrl.sv
// Link-level synchronization controller for a multi-lane receiver.
// Combines per-lane gating, the deglitching link state machine and the
// saturating error counter. Assumes all inputs are synchronous to clk.
module link_sync_ctrl
    import lsc_pkg::*;
#(
    parameter int NUM_LANES       = 4,
    parameter int DEGLITCH_CYCLES = 256,
    parameter int ERR_W           = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   link_en,
    input  logic [2*NUM_LANES-1:0] lane_phase,
    input  logic [NUM_LANES-1:0]   lane_err,
    input  logic [NUM_LANES-1:0]   lane_frame_err,
    output logic [1:0]             link_state,
    output logic                   link_synced,
    output logic [ERR_W-1:0]       err_count,
    output logic [NUM_LANES-1:0]   frame_err_evt
);

    logic [NUM_LANES-1:0] lane_in_data;
    logic                 all_data;
    logic                 enter_sync;

    lsc_lane_gate #(.NUM_LANES(NUM_LANES)) u_gate (
        .clk            (clk),
        .rst_n          (rst_n),
        .link_en        (link_en),
        .lane_phase     (lane_phase),
        .lane_frame_err (lane_frame_err),
        .lane_in_data   (lane_in_data),
        .frame_err_evt  (frame_err_evt)
    );

    // Link is all-DATA only when every lane reports DATA.
    always_comb begin
        all_data = &lane_in_data;
    end

    lsc_link_fsm #(.DEGLITCH_CYCLES(DEGLITCH_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_en    (link_en),
        .all_data   (all_data),
        .state      (link_state),
        .enter_sync (enter_sync)
    );

    lsc_err_counter #(.NUM_LANES(NUM_LANES), .ERR_W(ERR_W)) u_errs (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_en  (link_en),
        .clear    (enter_sync),
        .lane_err (lane_err),
        .count    (err_count)
    );

    // Synchronized flag decoded from the registered state.
    always_comb begin
        link_synced = (link_state == LS_SYNC);
    end

endmodule

// File: tb/tb_link_sync_ctrl.sv
module tb_link_sync_ctrl;

    localparam int N  = 4;
    localparam int EW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          link_en;
    logic [2*N-1:0] lane_phase;
    logic [N-1:0]  lane_err;
    logic [N-1:0]  lane_frame_err;
    logic [1:0]    link_state;
    logic          link_synced;
    logic [EW-1:0] err_count;
    logic [N-1:0]  frame_err_evt;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    int exp_cnt;

    always #2.5 clk = ~clk;

    link_sync_ctrl #(.NUM_LANES(N), .DEGLITCH_CYCLES(256), .ERR_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .lane_phase(lane_phase),
        .lane_err(lane_err), .lane_frame_err(lane_frame_err),
        .link_state(link_state), .link_synced(link_synced),
        .err_count(err_count), .frame_err_evt(frame_err_evt)
    );

    // Vector fields: phase[22:15] frame_err[14:11] lane_err[10:7] exp_evt[6:3] exp_inc[2:0]
    localparam int NV = 6;
    localparam logic [22:0] VEC [NV] = '{
        {8'b00000000, 4'b1111, 4'b0000, 4'b0000, 3'd0},
        {8'b00000010, 4'b1111, 4'b0001, 4'b0001, 3'd1},
        {8'b00100110, 4'b0101, 4'b1011, 4'b0101, 3'd3},
        {8'b10010101, 4'b1110, 4'b1111, 4'b1000, 3'd4},
        {8'b00001110, 4'b0011, 4'b0000, 4'b0001, 3'd0},
        {8'b01101010, 4'b1010, 4'b0110, 4'b0010, 3'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; link_en = 1'b0; lane_phase = '0;
        lane_err = '0; lane_frame_err = '0;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R1 reset state
        chk("R1 state", link_state, 0);
        chk("R1 synced", link_synced, 0);
        chk("R1 count", err_count, 0);
        chk("R1 evt", frame_err_evt, 0);
        link_en = 1'b1;
        edges(1);
        chk("R1 enable to waiting", link_state, 1);

        // Table walk: R6 gating and R9 counting while waiting
        exp_cnt = 0;
        for (int v = 0; v < NV; v++) begin
            lane_phase     = VEC[v][22:15];
            lane_frame_err = VEC[v][14:11];
            lane_err       = VEC[v][10:7];
            edges(1);
            exp_cnt += int'(VEC[v][2:0]);
            chk("R6 frame event gating", frame_err_evt, int'(VEC[v][6:3]));
            chk("R9 error accumulate", err_count, exp_cnt);
        end
        lane_frame_err = '0;
        lane_err = '0;
        chk("R2 still waiting", link_state, 1);

        // R3 dropout during deglitch
        lane_phase = 8'b10101010;
        edges(200);
        chk("R3 in deglitch", link_state, 2);
        lane_phase = 8'b10011010;
        edges(1);
        chk("R3 dropout back to waiting", link_state, 1);
        chk("R3 not synced", link_synced, 0);

        // R2 full window with errors to reach saturation (R8)
        lane_phase = 8'b10101010;
        lane_err   = 4'b0011;
        edges(255);
        chk("R2 not synced at 255", link_synced, 0);
        chk("R2 deglitch at 255", link_state, 2);
        chk("R8 saturated", err_count, 63);
        edges(1);
        chk("R2 synced at 256", link_synced, 1);
        chk("R4 cleared on entry", err_count, 0);

        // R5 accumulate after sync and hold sync despite lane drop
        lane_err = 4'b0001;
        edges(1);
        chk("R5 accumulates after sync", err_count, 1);
        lane_err = '0;
        lane_phase = 8'b00000000;
        lane_frame_err = 4'b1111;
        edges(5);
        chk("R5 stays synced", link_synced, 1);
        chk("R6 no event outside DATA", frame_err_evt, 0);
        chk("R5 count held", err_count, 1);

        // R7 disable
        lane_phase = 8'b10101010;
        lane_err = 4'b1111;
        link_en = 1'b0;
        edges(1);
        chk("R7 state idle", link_state, 0);
        chk("R7 not synced", link_synced, 0);
        chk("R7 count zero", err_count, 0);
        chk("R7 event zero", frame_err_evt, 0);
        edges(2);
        chk("R7 errors ignored", err_count, 0);
        chk("R7 events ignored", frame_err_evt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule